// File: doc/BRIEF.md
# Rotated Immediate Constant Expander

This block turns the 12-bit immediate field of a 32-bit data-processing instruction into the 32-bit operand constant that the datapath uses. The field packs an 8-bit base value and a 4-bit rotation count. The constant is the base value rotated right by twice the count inside a 32-bit word. Bits that leave the low end come back in at the high end, so the same base can be placed at any even bit position.

The block also gives the shifter carry-out that a flag-setting logical operation writes to its carry flag. When the rotation count is zero, the incoming carry flag passes through unchanged. In every other case the carry-out is the top bit of the expanded constant.

The `REG_STAGE` parameter picks one of two variants. With a register stage, the outputs are captured one cycle after a valid input and held until the next valid input. Without one, the path is purely combinational and the valid signal passes straight through.

Top module: `rimm_expand`

## Requirements
- R1: Field bits [7:0] are the 8-bit base value and field bits [11:8] are the 4-bit rotation count.
- R2: The constant is the base, zero-extended to 32 bits and rotated right by 2*count. Bits that rotate out of bit 0 wrap into bit 31 and downward.
- R3: A count of zero gives the base value zero-extended to 32 bits.
- R4: A count of zero makes carry_out equal to carry_in, so the flag is left unchanged.
- R5: A nonzero count makes carry_out equal to bit 31 of the expanded constant.
- R6: Field 0x808 expands to 0x00080000.
- R7: Field 0xEFF expands to 0x00000FF0 with carry_out 0, and field 0x2FF expands to 0xF000000F with carry_out 1, whatever carry_in is.
- R8: With the register stage, out_valid is high exactly in the cycle after a cycle in which in_valid is high, and the outputs in that cycle belong to that input.
- R9: With the register stage, const_out and carry_out keep their values through cycles in which in_valid is low, even if field and carry_in change.
- R10: The expanded constant has the same number of one bits as the base value.
- R11: With the register stage, synchronous active-high reset clears out_valid, const_out and carry_out to 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the register stage |
| rst | input | 1 | Synchronous active-high reset |
| in_valid | input | 1 | Field and carry_in are valid this cycle |
| field | input | 12 | Rotated immediate field: count in [11:8], base in [7:0] |
| carry_in | input | 1 | Current carry flag |
| out_valid | output | 1 | const_out and carry_out are valid |
| const_out | output | 32 | Expanded 32-bit constant |
| carry_out | output | 1 | Shifter carry-out for flag-setting logical operations |

## Verification
The bench drives every one of the 4096 field values and compares both outputs with a bit-by-bit rotation model. This catches a design that shifts instead of rotating, because high-order bits of the base would then vanish. It also catches a design that rotates left or rotates by the count instead of twice the count, because most constants would then land in the wrong place. Count-zero fields are run with both carry_in values, so a carry that comes from bit 31 or is forced to zero would show up whenever bit 31 and carry_in differ. Random idle cycles, with field and carry_in changing while in_valid is low, expose a register stage that loads when it should hold.

// File: rtl/rimm_pkg.sv
package rimm_pkg;
    parameter int WORD_W  = 32;
    parameter int BASE_W  = 8;
    parameter int CNT_W   = 4;
    localparam int FIELD_W = BASE_W + CNT_W;
    localparam int AMT_W   = CNT_W + 1;

    typedef logic [WORD_W-1:0] word_t;

    typedef struct packed {
        logic [CNT_W-1:0]  count;
        logic [BASE_W-1:0] base;
    } imm_field_t;

    typedef struct packed {
        word_t value;
        logic  carry;
    } imm_result_t;

    // the rotation distance is always even: twice the count
    function automatic logic [AMT_W-1:0] rot_amount(input logic [CNT_W-1:0] c);
        return {c, 1'b0};
    endfunction
endpackage

// File: rtl/rimm_rotator.sv
module rimm_rotator
    import rimm_pkg::*;
(
    input  imm_field_t fld,
    output word_t      value
);
    logic [WORD_W-1:0]   ext;
    logic [2*WORD_W-1:0] dbl;
    logic [2*WORD_W-1:0] shifted;

    assign ext     = {{(WORD_W-BASE_W){1'b0}}, fld.base};
    // a doubled word shifted right gives a right rotation in its low half
    assign dbl     = {ext, ext};
    assign shifted = dbl >> rot_amount(fld.count);
    assign value   = shifted[WORD_W-1:0];
endmodule

// File: rtl/rimm_carry_sel.sv
module rimm_carry_sel
    import rimm_pkg::*;
(
    input  logic [CNT_W-1:0] count,
    input  logic             value_msb,
    input  logic             carry_in,
    output logic             carry
);
    always_comb begin
        if (count == '0) carry = carry_in;
        else             carry = value_msb;
    end
endmodule

// File: rtl/rimm_out_stage.sv
module rimm_out_stage
    import rimm_pkg::*;
#(
    parameter bit REG_STAGE = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        in_valid,
    input  imm_result_t nxt,
    output logic        out_valid,
    output imm_result_t res
);
    generate
        if (REG_STAGE) begin : g_reg
            always_ff @(posedge clk) begin
                if (rst) begin
                    out_valid <= 1'b0;
                    res       <= '0;
                end else begin
                    out_valid <= in_valid;
                    if (in_valid) res <= nxt;
                end
            end
        end else begin : g_comb
            assign out_valid = in_valid;
            assign res       = nxt;
        end
    endgenerate
endmodule

// File: rtl/rimm_expand.sv
module rimm_expand
    import rimm_pkg::*;
#(
    parameter bit REG_STAGE = 1'b1
) (
    input  logic               clk,
    input  logic               rst,
    input  logic               in_valid,
    input  logic [FIELD_W-1:0] field,
    input  logic               carry_in,
    output logic               out_valid,
    output logic [WORD_W-1:0]  const_out,
    output logic               carry_out
);
    imm_field_t  fld;
    imm_result_t nxt;
    imm_result_t res;
    word_t       rot_value;
    logic        sel_carry;

    assign fld = imm_field_t'(field);

    rimm_rotator u_rot (
        .fld   (fld),
        .value (rot_value)
    );

    rimm_carry_sel u_carry (
        .count     (fld.count),
        .value_msb (rot_value[WORD_W-1]),
        .carry_in  (carry_in),
        .carry     (sel_carry)
    );

    assign nxt.value = rot_value;
    assign nxt.carry = sel_carry;

    rimm_out_stage #(.REG_STAGE(REG_STAGE)) u_out (
        .clk       (clk),
        .rst       (rst),
        .in_valid  (in_valid),
        .nxt       (nxt),
        .out_valid (out_valid),
        .res       (res)
    );

    assign const_out = res.value;
    assign carry_out = res.carry;

    // R10
    ones_kept_chk: assert property (@(posedge clk) disable iff (rst)
        $countones(rot_value) == $countones(fld.base));

    // R3
    zero_rot_chk: assert property (@(posedge clk) disable iff (rst)
        (fld.count == '0) |-> (rot_value == word_t'(fld.base)));

    generate
        if (REG_STAGE) begin : g_chk
            // R8
            valid_rise_chk: assert property (@(posedge clk) disable iff (rst)
                in_valid |=> out_valid);
            // R8
            valid_idle_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> !out_valid);
            // R9
            hold_chk: assert property (@(posedge clk) disable iff (rst)
                !in_valid |=> ($stable(const_out) && $stable(carry_out)));
            // R4
            carry_keep_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && fld.count == '0) |=> (carry_out == $past(carry_in)));
            // R5
            carry_msb_chk: assert property (@(posedge clk) disable iff (rst)
                (in_valid && fld.count != '0) |=> (carry_out == const_out[WORD_W-1]));
        end
    endgenerate
endmodule

// File: tb/test_rimm_expand.sv
module test_rimm_expand;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        in_valid = 1'b0;
    logic [11:0] field = '0;
    logic        carry_in = 1'b0;
    logic        out_valid;
    logic [31:0] const_out;
    logic        carry_out;

    int n_checks = 0;
    int n_fail   = 0;
    bit done     = 1'b0;

    always #10 clk = ~clk;

    rimm_expand i_rimm_expand (
        .clk(clk), .rst(rst), .in_valid(in_valid), .field(field),
        .carry_in(carry_in), .out_valid(out_valid),
        .const_out(const_out), .carry_out(carry_out)
    );

    function automatic logic [31:0] ref_const(input logic [11:0] f);
        logic [31:0] src;
        logic [31:0] r;
        int amt;
        src = {24'd0, f[7:0]};
        amt = 2 * int'(f[11:8]);
        for (int i = 0; i < 32; i++) r[i] = src[(i + amt) % 32];
        return r;
    endfunction

    function automatic logic ref_carry(input logic [11:0] f, input logic c);
        logic [31:0] v;
        v = ref_const(f);
        return (f[11:8] == 4'd0) ? c : v[31];
    endfunction

    task automatic check(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    // drive at negedge, sample one negedge later (one register stage)
    task automatic apply(input logic [11:0] f, input logic c, input string req);
        logic [31:0] ev;
        logic ec;
        field = f; carry_in = c; in_valid = 1'b1;
        @(negedge clk);
        ev = ref_const(f);
        ec = ref_carry(f, c);
        check(out_valid === 1'b1, "R8 out_valid", {31'd0, out_valid}, 32'd1);
        check(const_out === ev, {req, " const"}, const_out, ev);
        check(carry_out === ec, {req, " carry"}, {31'd0, carry_out}, {31'd0, ec});
        in_valid = 1'b0;
    endtask

    task automatic idle(input int cycles);
        logic [31:0] hv;
        logic hc;
        hv = const_out; hc = carry_out;
        for (int k = 0; k < cycles; k++) begin
            field = 12'($urandom); carry_in = 1'($urandom);
            @(negedge clk);
            check(out_valid === 1'b0, "R8 idle valid", {31'd0, out_valid}, 32'd0);
            check(const_out === hv && carry_out === hc, "R9 hold", const_out, hv);
        end
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_checks++; n_fail++;
            $display("FAIL watchdog expired actual=%h expected=%h", 0, 1);
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd20240611));
        repeat (3) @(negedge clk);
        // R11 reset state
        check(out_valid === 1'b0 && const_out === 32'd0 && carry_out === 1'b0,
              "R11 reset", const_out, 32'd0);
        rst = 1'b0;
        @(negedge clk);

        // R6 directed
        apply(12'h808, 1'b0, "R6");
        check(const_out === 32'h0008_0000, "R6 literal", const_out, 32'h0008_0000);
        // R7 directed, both carry_in values
        for (int c = 0; c < 2; c++) begin
            apply(12'hEFF, 1'(c), "R7");
            check(const_out === 32'h0000_0FF0 && carry_out === 1'b0, "R7 0xFF0", const_out, 32'h0000_0FF0);
            apply(12'h2FF, 1'(c), "R7");
            check(const_out === 32'hF000_000F && carry_out === 1'b1, "R7 0xF000000F", const_out, 32'hF000_000F);
        end
        // R3 R4 zero count with both carries; R1 base placement
        for (int c = 0; c < 2; c++) begin
            apply(12'h0A5, 1'(c), "R3 R4");
            check(carry_out === 1'(c), "R4 passthrough", {31'd0, carry_out}, c);
            check(const_out === 32'h0000_00A5, "R1 base low", const_out, 32'hA5);
        end
        // R5 nonzero count where bit31 differs from carry_in
        apply(12'h1C1, 1'b0, "R5");
        check(carry_out === 1'b0 && const_out === 32'h4000_0030, "R5 msb0", const_out, 32'h4000_0030);
        apply(12'h182, 1'b0, "R5");
        check(carry_out === 1'b1, "R5 msb1", {31'd0, carry_out}, 32'd1);
        idle(3);

        // R2 R10 exhaustive sweep with random carry and random idle gaps
        for (int f = 0; f < 4096; f++) begin
            logic [31:0] v;
            apply(12'(f), 1'($urandom), "R2");
            v = ref_const(12'(f));
            check($countones(const_out) == $countones(f[7:0]), "R10 ones", const_out, v);
            if ($urandom_range(0, 15) == 0) idle(int'($urandom_range(1, 3)));
        end

        done = 1'b1;
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule